// File: doc/BRIEF.md
# Fixed-Point to Floating-Point Normalizer

This block turns a signed-magnitude fixed-point number into a floating-point triple: a sign bit, a biased exponent field and a mantissa field. The magnitude is an unsigned Q16.16 word. The sign arrives on its own input and is never folded into the magnitude. A conversion begins with a one-cycle start pulse. The block then moves the magnitude one bit position per clock until the value has the form 0.1xxx. It moves right when the integer part is non-zero and left when the value is below one half. A signed counter records the net number of positions moved, and that count is the true exponent E, where value = 0.1xxx · 2^E.

A single-cycle done pulse marks the clock in which the result outputs become valid. The result outputs then hold until the next done. A format select, sampled together with start, chooses between two output forms:
- **Excess-128 form:** the leading 1 is kept in the top mantissa bit, and the exponent field is E + 128.
- **Hidden-bit form:** the value is read as 1.xxx · 2^(E-1) with bias 127, so the exponent field is E + 126 and the leading 1 is not stored.

Rounding, denormals, infinities and NaN are not produced. Mantissa bits beyond the 23-bit field are truncated.

Top module: `fxp_flt_normalizer`

## Requirements
- R1: After reset, done and busy are 0 and sign_out, exp_out and mant_out are all 0.
- R2: A start pulse while busy is 0 latches sign_in, mag_in and fmt_sel, and busy reads 1 in the following cycle.
- R3: The magnitude moves exactly one bit position per clock. For a non-zero input whose true exponent is E, done is high exactly |E|+1 cycles after the clock edge that sampled start.
- R4: With fmt_sel = 0 (excess-128 form), exp_out = E + 128, where E is the integer that places the leading 1 immediately after the binary point. For a Q16.16 input whose highest set bit is bit m, E = m - 15. An input of 98.6 (0x00629999) gives exp_out = 135.
- R5: With fmt_sel = 0, mant_out holds the 23 bits that follow the binary point after normalization. Bit 22 is the leading 1, and lower bits are truncated. For 0x00629999 this is 0x629999.
- R6: With fmt_sel = 1 (hidden-bit form), exp_out = E + 126 and mant_out holds the 23 bits that follow the leading 1, which is not stored.
- R7: A value below 0.5 is shifted left and gives a negative E. For example, 0x00000001 gives E = -15, and 0x00004000 gives E = -1.
- R8: A zero magnitude performs no shift. done is high 1 cycle after the start edge, exp_out and mant_out are 0, and sign_out carries the latched sign.
- R9: sign_out equals the sign latched at start, whatever the magnitude.
- R10: A start pulse while busy is 1 is ignored. The running conversion completes with its own operands, and no second done follows.
- R11: done is high for exactly one cycle per conversion, and sign_out, exp_out and mant_out keep their values until the next done.
- R12: In the hidden-bit form, a non-zero input never yields an exponent field of all zeros or all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a conversion |
| fmt_sel | input | 1 | 0 selects the excess-128 form with the leading 1 kept; 1 selects the bias-127 form with a hidden bit |
| sign_in | input | 1 | Sign of the number (1 = negative) |
| mag_in | input | 32 | Unsigned Q16.16 magnitude |
| busy | output | 1 | High while a conversion is in progress |
| done | output | 1 | One-cycle pulse when a result is valid |
| sign_out | output | 1 | Sign of the result |
| exp_out | output | 8 | Biased exponent field |
| mant_out | output | 23 | Mantissa field |

## Verification
The assertions assume three things about the inputs:
- start is a single-cycle pulse.
- sign_in, mag_in and fmt_sel are only meaningful in the cycle that start is sampled while the block is idle.
- The Q16.16 magnitude bounds the shift count to the range -15 to +16, so the exponent field never wraps.

The directed tasks keep to these conditions. Every input is driven on the falling edge, and start is held for exactly one clock. A new start is issued either after done or deliberately while busy is high, to show that it is ignored. The operands cover both shift directions, exact powers of two, zero, and the largest magnitude.

// File: rtl/fxp_norm_pkg.sv
package fxp_norm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } norm_state_e;

    typedef enum logic {
        FMT_EXCESS = 1'b0,
        FMT_HIDDEN = 1'b1
    } norm_fmt_e;

endpackage

// File: rtl/fxp_norm_ctrl.sv
module fxp_norm_ctrl
    import fxp_norm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_zero,
    input  logic is_norm,
    output logic load,
    output logic step,
    output logic capture,
    output logic busy
);

    norm_state_e st_d, st_q;

    always_comb begin
        st_d    = st_q;
        load    = 1'b0;
        step    = 1'b0;
        capture = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    st_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (is_zero || is_norm) begin
                    capture = 1'b1;
                    st_d    = ST_IDLE;
                end else begin
                    step = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign busy = (st_q == ST_RUN);

    // A zero magnitude is finished on the first running cycle
    p_zero_no_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_zero) |-> !step);

    // Loading is only possible from idle; while running start has no effect
    p_no_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !load);

endmodule

// File: rtl/fxp_norm_shifter.sv
module fxp_norm_shifter #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load,
    input  logic                           step,
    input  logic [INT_W+FRAC_W-1:0]        mag_in,
    output logic [2*INT_W+FRAC_W-1:0]      acc,
    output logic [CNT_W-1:0]               cnt,
    output logic                           is_zero,
    output logic                           is_norm
);

    localparam int ACC_W = 2 * INT_W + FRAC_W;
    localparam int PT    = ACC_W - INT_W;   // bits below the binary point

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
    } shf_t;

    shf_t s_d, s_q;
    logic too_big;

    assign too_big = |s_q.acc[ACC_W-1:PT];
    assign is_zero = ~|s_q.acc;
    assign is_norm = !too_big && s_q.acc[PT-1];

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.acc = {mag_in, {INT_W{1'b0}}};
            s_d.cnt = '0;
        end else if (step) begin
            if (too_big) begin
                s_d.acc = s_q.acc >> 1;
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end else begin
                s_d.acc = s_q.acc << 1;
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acc = s_q.acc;
    assign cnt = s_q.cnt;

    // One position per clock: the counter moves by exactly one
    p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ((s_q.cnt == $past(s_q.cnt) + CNT_W'(1)) ||
                  (s_q.cnt == $past(s_q.cnt) - CNT_W'(1))));

    // No set bit is lost while moving; truncation happens only at the output
    p_bits_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ($countones(s_q.acc) == $past($countones(s_q.acc))));

    // Exponent stays inside the range the Q format allows
    p_exp_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(s_q.cnt) <= $signed(CNT_W'(INT_W))) &&
        ($signed(s_q.cnt) >= -$signed(CNT_W'(FRAC_W - 1))));

endmodule

// File: rtl/fxp_norm_packer.sv
module fxp_norm_packer #(
    parameter int EXP_W  = 8,
    parameter int MANT_W = 23,
    parameter int CNT_W  = 8
) (
    input  logic [MANT_W:0]      frac_top,
    input  logic [CNT_W-1:0]     cnt,
    input  logic                 is_zero,
    input  logic                 fmt,
    output logic [EXP_W-1:0]     exp_field,
    output logic [MANT_W-1:0]    mant_field
);

    localparam int EXT_W = EXP_W + CNT_W;
    localparam logic signed [EXT_W-1:0] BIAS_EXCESS = EXT_W'(2 ** (EXP_W - 1));
    localparam logic signed [EXT_W-1:0] BIAS_HIDDEN = EXT_W'(2 ** (EXP_W - 1) - 2);

    logic signed [EXT_W-1:0] e_ext;

    always_comb begin
        e_ext = EXT_W'($signed(cnt)) + (fmt ? BIAS_HIDDEN : BIAS_EXCESS);
        if (is_zero) begin
            exp_field  = '0;
            mant_field = '0;
        end else begin
            exp_field  = e_ext[EXP_W-1:0];
            mant_field = fmt ? frac_top[MANT_W-1:0] : frac_top[MANT_W:1];
        end
    end

endmodule

// File: rtl/fxp_flt_normalizer.sv
module fxp_flt_normalizer
    import fxp_norm_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 16,
    parameter int EXP_W  = 8,
    parameter int MANT_W = 23
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    fmt_sel,
    input  logic                    sign_in,
    input  logic [INT_W+FRAC_W-1:0] mag_in,
    output logic                    busy,
    output logic                    done,
    output logic                    sign_out,
    output logic [EXP_W-1:0]        exp_out,
    output logic [MANT_W-1:0]       mant_out
);

    localparam int IN_W  = INT_W + FRAC_W;
    localparam int ACC_W = 2 * INT_W + FRAC_W;
    localparam int PT    = ACC_W - INT_W;
    localparam int CNT_W = $clog2(ACC_W) + 2;

    typedef struct packed {
        logic              sign;
        norm_fmt_e         fmt;
        logic              done;
        logic              r_sign;
        logic              r_zero;
        logic [EXP_W-1:0]  r_exp;
        logic [MANT_W-1:0] r_mant;
    } top_t;

    top_t t_d, t_q;

    logic              load, step, capture, busy_w;
    logic [ACC_W-1:0]  acc;
    logic [CNT_W-1:0]  cnt;
    logic              is_zero, is_norm;
    logic [EXP_W-1:0]  exp_field;
    logic [MANT_W-1:0] mant_field;

    fxp_norm_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .is_zero (is_zero),
        .is_norm (is_norm),
        .load    (load),
        .step    (step),
        .capture (capture),
        .busy    (busy_w)
    );

    fxp_norm_shifter #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W),
        .CNT_W  (CNT_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .mag_in  (mag_in),
        .acc     (acc),
        .cnt     (cnt),
        .is_zero (is_zero),
        .is_norm (is_norm)
    );

    fxp_norm_packer #(
        .EXP_W  (EXP_W),
        .MANT_W (MANT_W),
        .CNT_W  (CNT_W)
    ) u_pack (
        .frac_top   (acc[PT-1 -: MANT_W+1]),
        .cnt        (cnt),
        .is_zero    (is_zero),
        .fmt        (t_q.fmt == FMT_HIDDEN),
        .exp_field  (exp_field),
        .mant_field (mant_field)
    );

    always_comb begin
        t_d      = t_q;
        t_d.done = 1'b0;
        if (load) begin
            t_d.sign = sign_in;
            t_d.fmt  = fmt_sel ? FMT_HIDDEN : FMT_EXCESS;
        end
        if (capture) begin
            t_d.done   = 1'b1;
            t_d.r_sign = t_q.sign;
            t_d.r_zero = is_zero;
            t_d.r_exp  = exp_field;
            t_d.r_mant = mant_field;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy     = busy_w;
    assign done     = t_q.done;
    assign sign_out = t_q.r_sign;
    assign exp_out  = t_q.r_exp;
    assign mant_out = t_q.r_mant;

    // Operands latched at start stay put while a conversion runs
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && start) |=> ($stable(t_q.sign) && $stable(t_q.fmt)));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.done |=> !t_q.done);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !t_q.done |-> ($stable(t_q.r_exp) && $stable(t_q.r_mant) && $stable(t_q.r_sign)));

    // Excess form keeps the leading one in the top mantissa bit
    p_lead_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.done && !t_q.r_zero && t_q.fmt == FMT_EXCESS) |-> t_q.r_mant[MANT_W-1]);

    p_zero_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.done && t_q.r_zero) |-> (t_q.r_exp == '0 && t_q.r_mant == '0));

    p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.done && !t_q.r_zero && t_q.fmt == FMT_HIDDEN) |->
            (t_q.r_exp != '0 && t_q.r_exp != '1));

    p_done_not_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.done |-> !busy_w || $past(start));

endmodule

// File: tb/tb_fxp_flt_normalizer.sv
module tb_fxp_flt_normalizer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        fmt_sel = 1'b0;
    logic        sign_in = 1'b0;
    logic [31:0] mag_in = '0;
    logic        busy, done, sign_out;
    logic [7:0]  exp_out;
    logic [22:0] mant_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;   // 4 ns period

    fxp_flt_normalizer dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .fmt_sel  (fmt_sel),
        .sign_in  (sign_in),
        .mag_in   (mag_in),
        .busy     (busy),
        .done     (done),
        .sign_out (sign_out),
        .exp_out  (exp_out),
        .mant_out (mant_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Reference model from the requirements
    task automatic model(input logic [31:0] m, input logic fmt,
                         output int e, output logic [7:0] ef, output logic [22:0] mf);
        int msb = 0;
        logic [63:0] x;
        for (int i = 0; i < 32; i++) if (m[i]) msb = i;
        x = {m, 32'b0};
        if (m == 0) begin
            e = 0; ef = '0; mf = '0;
        end else begin
            e = msb - 15;
            if (!fmt) begin
                ef = 8'(e + 128);
                mf = 23'(x >> (msb + 10));
            end else begin
                ef = 8'(e + 126);
                mf = 23'(x >> (msb + 9));
            end
        end
    endtask

    task automatic pulse_start(input logic s, input logic [31:0] m, input logic f);
        @(negedge clk);
        sign_in = s; mag_in = m; fmt_sel = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic run_case(input string req, input logic s, input logic [31:0] m,
                            input logic f);
        int e, cyc, nsh;
        logic [7:0] ef;
        logic [22:0] mf;
        model(m, f, e, ef, mf);
        nsh = (m == 0) ? 0 : (e < 0 ? -e : e);
        pulse_start(s, m, f);
        check(busy === 1'b1, "R2", "busy after start", 32'(busy), 32'd1);
        wait_done(cyc);
        check(cyc == nsh + 1, "R3", "latency", 32'(cyc), 32'(nsh + 1));
        check(exp_out === ef, req, "exp", 32'(exp_out), 32'(ef));
        check(mant_out === mf, req, "mant", 32'(mant_out), 32'(mf));
        check(sign_out === s, "R9", "sign", 32'(sign_out), 32'(s));
    endtask

    task automatic t_reset;
        check(done === 1'b0 && busy === 1'b0, "R1", "done/busy after reset",
              32'({done, busy}), 32'd0);
        check(exp_out === '0 && mant_out === '0 && sign_out === 1'b0, "R1",
              "outputs after reset", 32'(mant_out), 32'd0);
    endtask

    task automatic t_example;
        int cyc;
        pulse_start(1'b0, 32'h0062_9999, 1'b0);
        wait_done(cyc);
        check(exp_out === 8'd135, "R4", "98.6 exponent", 32'(exp_out), 32'd135);
        check(mant_out === 23'h629999, "R5", "98.6 mantissa", 32'(mant_out), 32'h629999);
        check(cyc == 8, "R3", "98.6 latency", 32'(cyc), 32'd8);
    endtask

    task automatic t_right_shifts;
        run_case("R4", 1'b0, 32'hFFFF_FFFF, 1'b0);
        run_case("R5", 1'b1, 32'h0001_8000, 1'b0);
        run_case("R4", 1'b0, 32'h0000_8000, 1'b0);
    endtask

    task automatic t_left_shifts;
        run_case("R7", 1'b0, 32'h0000_0001, 1'b0);
        check(exp_out === 8'd113, "R7", "2^-16 exponent", 32'(exp_out), 32'd113);
        run_case("R7", 1'b1, 32'h0000_4000, 1'b0);
        check(exp_out === 8'd127, "R7", "0.25 exponent", 32'(exp_out), 32'd127);
        run_case("R7", 1'b0, 32'h0000_2345, 1'b1);
    endtask

    task automatic t_hidden;
        run_case("R6", 1'b0, 32'h0001_8000, 1'b1);
        check(exp_out === 8'd127 && mant_out === 23'h400000, "R6", "1.5 hidden",
              32'({exp_out, mant_out}), 32'({8'd127, 23'h400000}));
        run_case("R6", 1'b0, 32'h0062_9999, 1'b1);
        run_case("R12", 1'b1, 32'hFFFF_FFFF, 1'b1);
        check(exp_out != 8'hFF && exp_out != 8'h00, "R12", "max not reserved",
              32'(exp_out), 32'd142);
        run_case("R12", 1'b0, 32'h0000_0001, 1'b1);
        check(exp_out != 8'h00, "R12", "min not reserved", 32'(exp_out), 32'd111);
    endtask

    task automatic t_zero;
        run_case("R8", 1'b1, 32'h0, 1'b0);
        run_case("R8", 1'b0, 32'h0, 1'b1);
    endtask

    task automatic t_busy_ignore;
        int cyc, extra;
        pulse_start(1'b0, 32'hFFFF_0000, 1'b0);
        @(negedge clk);
        check(busy === 1'b1, "R10", "busy mid run", 32'(busy), 32'd1);
        sign_in = 1'b1; mag_in = 32'h0000_0003; fmt_sel = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
        check(exp_out === 8'd144 && mant_out === 23'h7FFF80, "R10", "first operands kept",
              32'({exp_out, mant_out}), 32'({8'd144, 23'h7FFF80}));
        check(sign_out === 1'b0, "R10", "first sign kept", 32'(sign_out), 32'd0);
        extra = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check(extra == 0 && busy === 1'b0, "R10", "no second done", 32'(extra), 32'd0);
    endtask

    task automatic t_pulse_hold;
        int cyc;
        logic [7:0] e0;
        logic [22:0] m0;
        logic s0;
        pulse_start(1'b1, 32'h0003_0000, 1'b0);
        wait_done(cyc);
        e0 = exp_out; m0 = mant_out; s0 = sign_out;
        @(negedge clk);
        check(done === 1'b0, "R11", "done one cycle", 32'(done), 32'd0);
        sign_in = 1'b0; mag_in = 32'h1234_5678; fmt_sel = 1'b1;
        repeat (5) @(negedge clk);
        check(exp_out === e0 && mant_out === m0 && sign_out === s0, "R11", "hold",
              32'({exp_out, mant_out}), 32'({e0, m0}));
        check(e0 === 8'd130 && m0 === 23'h600000, "R4", "3.0 result",
              32'({e0, m0}), 32'({8'd130, 23'h600000}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_example();
        t_right_shifts();
        t_left_shifts();
        t_hidden();
        t_zero();
        t_busy_ignore();
        t_pulse_hold();
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule